// File: doc/BRIEF.md
# Weighted Two-Initiator Bus Arbiter

This block decides which of two initiators may use a shared external memory interface next. One initiator is a direct interconnect port. The other is a background engine that prefetches reads and posts writes. Each initiator holds a level request. The arbiter answers with a one-cycle grant pulse. It then treats the bus as owned until the memory side returns a one-cycle transaction-done pulse. Only one transaction is outstanding at any time.

Two policies are available. In fixed-priority mode the direct port always wins when both initiators ask. In weighted round-robin mode, contention is settled in rounds: one direct grant, then a run of engine grants. The run is one longer than the value on the weight input, and that value is captured when the run begins. The round state clears whenever either initiator stops requesting. An owner output shows which initiator holds the bus, so the grant sequence can be checked.

Top module: `wrr_bus_arbiter`

## Requirements
- R1: While rst_n is low (synchronous, active-low), and on the first cycle after release, dir_gnt and eng_gnt are 0 and owner is 0 (idle).
- R2: dir_gnt and eng_gnt are never high together. A grant lasts exactly one cycle. No grant is issued while owner is nonzero.
- R3: A grant issued at a clock edge sets owner at that same edge: 1 for direct, 2 for engine. Owner holds that value until the edge that samples xfer_done high, and returns to 0 at that edge.
- R4: When the bus is idle and exactly one initiator requests, that initiator is granted at the next edge, in either mode.
- R5: With mode_wrr low and both initiators requesting on a free bus, the direct port is granted every time.
- R6: With mode_wrr high and both initiators requesting continuously, grants repeat as one direct grant followed by weight+1 engine grants. Weight 2 gives D,E,E,E and weight 0 gives D,E.
- R7: If the engine has been granted alone and the direct port then begins requesting, the next free slot goes to the direct port.
- R8: Any free slot at which the two requests are not both high clears the pending engine run. The next contended slot then goes to the direct port.
- R9: The weight input is captured at the direct grant that starts a round. A change during the engine run takes effect only in the following round.
- R10: An xfer_done pulse while owner is 0 has no effect: no grant appears and owner stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_req | input | 1 | Direct port request (level) |
| eng_req | input | 1 | Engine request (level) |
| xfer_done | input | 1 | One-cycle end-of-transaction pulse from the memory side |
| mode_wrr | input | 1 | 1 = weighted round-robin, 0 = direct port has fixed priority |
| weight | input | WEIGHT_W (4) | Extra engine grants per round |
| dir_gnt | output | 1 | One-cycle grant to the direct port |
| eng_gnt | output | 1 | One-cycle grant to the engine |
| owner | output | 2 | Current bus owner: 0 idle, 1 direct, 2 engine |

## Verification
Two of the block's functions can act in the same cycle: the done pulse that frees the bus, and a change in the request pattern that clears or starts a round. The bench provokes this by changing requests in the cycle right after a grant, so the new levels are sampled exactly where the done pulse frees the bus. Examples are a direct request arriving, a direct request dropping, or the weight changing mid-run. Each case is judged by the order of grants, which a scoreboard compares against the sequence worked out from the requirements.

// File: rtl/wrr_arb_pkg.sv
package wrr_arb_pkg;
   typedef enum logic [1:0] {
      OWN_IDLE = 2'd0,
      OWN_DIR  = 2'd1,
      OWN_ENG  = 2'd2
   } owner_e;
endpackage

// File: rtl/wrr_arb_pick.sv
// Combinational choice for the next free slot.
module wrr_arb_pick (
   input  logic dir_req,
   input  logic eng_req,
   input  logic mode_wrr,
   input  logic run_owed,
   output logic pick_dir,
   output logic pick_eng
);
   logic both;
   assign both = dir_req & eng_req;

   always_comb begin
      pick_dir = dir_req;
      pick_eng = eng_req;
      if (both) begin
         // engine owed more grants in this round takes the slot
         pick_eng = mode_wrr & run_owed;
         pick_dir = ~pick_eng;
      end
   end
endmodule

// File: rtl/wrr_arb_run_ctr.sv
// Counts the engine grants still owed in the current round.
module wrr_arb_run_ctr #(
   parameter int unsigned WEIGHT_W = 4,
   parameter bit          HAS_WRR  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                both_req,
   input  logic                mode_wrr,
   input  logic                slot_free,
   input  logic                start_run,
   input  logic                eng_step,
   input  logic [WEIGHT_W-1:0] weight,
   output logic                run_owed
);
   localparam int unsigned CNT_W = WEIGHT_W + 1;

   generate
      if (HAS_WRR) begin : g_wrr
         logic [CNT_W-1:0] owed_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               owed_q <= '0;
            end else if (!mode_wrr || (slot_free && !both_req)) begin
               owed_q <= '0;
            end else if (start_run) begin
               owed_q <= {1'b0, weight} + CNT_W'(1);
            end else if (eng_step && owed_q != '0) begin
               owed_q <= owed_q - CNT_W'(1);
            end
         end

         assign run_owed = (owed_q != '0);
      end else begin : g_fixed
         logic unused_ok;
         assign unused_ok = &{1'b0, clk, rst_n, both_req, mode_wrr,
                              slot_free, start_run, eng_step, weight};
         assign run_owed  = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/wrr_arb_slot.sv
// Grant pulses and bus ownership tracking.
module wrr_arb_slot
   import wrr_arb_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   issue_dir,
   input  logic   issue_eng,
   input  logic   xfer_done,
   output logic   dir_gnt,
   output logic   eng_gnt,
   output owner_e owner,
   output logic   busy
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_gnt <= 1'b0;
         eng_gnt <= 1'b0;
         owner   <= OWN_IDLE;
      end else begin
         dir_gnt <= issue_dir;
         eng_gnt <= issue_eng;
         if (issue_dir)
            owner <= OWN_DIR;
         else if (issue_eng)
            owner <= OWN_ENG;
         else if (xfer_done)
            owner <= OWN_IDLE;
      end
   end

   assign busy = (owner != OWN_IDLE);
endmodule

// File: rtl/wrr_bus_arbiter.sv
module wrr_bus_arbiter
   import wrr_arb_pkg::*;
#(
   parameter int unsigned WEIGHT_W = 4,
   parameter bit          HAS_WRR  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                dir_req,
   input  logic                eng_req,
   input  logic                xfer_done,
   input  logic                mode_wrr,
   input  logic [WEIGHT_W-1:0] weight,
   output logic                dir_gnt,
   output logic                eng_gnt,
   output logic [1:0]          owner
);
   generate
      if (WEIGHT_W < 1 || WEIGHT_W > 8) begin : g_bad_weight
         $error("wrr_bus_arbiter: WEIGHT_W must be 1..8");
      end
   endgenerate

   logic   busy, run_owed, pick_dir, pick_eng;
   logic   issue_dir, issue_eng, both_req;
   owner_e owner_q;

   assign both_req  = dir_req & eng_req;
   assign issue_dir = ~busy & pick_dir;
   assign issue_eng = ~busy & pick_eng;

   wrr_arb_pick u_pick (
      .dir_req  (dir_req),
      .eng_req  (eng_req),
      .mode_wrr (mode_wrr),
      .run_owed (run_owed),
      .pick_dir (pick_dir),
      .pick_eng (pick_eng)
   );

   wrr_arb_run_ctr #(
      .WEIGHT_W (WEIGHT_W),
      .HAS_WRR  (HAS_WRR)
   ) u_run (
      .clk       (clk),
      .rst_n     (rst_n),
      .both_req  (both_req),
      .mode_wrr  (mode_wrr),
      .slot_free (~busy),
      .start_run (issue_dir & both_req),
      .eng_step  (issue_eng & both_req),
      .weight    (weight),
      .run_owed  (run_owed)
   );

   wrr_arb_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .issue_dir (issue_dir),
      .issue_eng (issue_eng),
      .xfer_done (xfer_done),
      .dir_gnt   (dir_gnt),
      .eng_gnt   (eng_gnt),
      .owner     (owner_q),
      .busy      (busy)
   );

   assign owner = owner_q;
endmodule

// File: rtl/wrr_arb_chk.sv
module wrr_arb_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       dir_req,
   input logic       eng_req,
   input logic       xfer_done,
   input logic       mode_wrr,
   input logic       dir_gnt,
   input logic       eng_gnt,
   input logic [1:0] owner
);
   // R2
   gnt_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(dir_gnt && eng_gnt));

   // R2
   gnt_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_gnt || eng_gnt) |=> !(dir_gnt || eng_gnt));

   // R3
   owner_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dir_gnt |-> owner == 2'd1);

   // R3
   owner_eng_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_gnt |-> owner == 2'd2);

   // R3
   owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (owner != 2'd0 && !xfer_done) |=> $stable(owner));

   // R3
   owner_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (owner != 2'd0 && xfer_done) |=> owner == 2'd0);

   // R4
   lone_eng_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (owner == 2'd0 && eng_req && !dir_req) |=> eng_gnt);

   // R4
   lone_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (owner == 2'd0 && dir_req && !eng_req) |=> dir_gnt);

   // R5
   fixed_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (owner == 2'd0 && !mode_wrr && dir_req && eng_req) |=> dir_gnt);

   // R10
   idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (owner == 2'd0 && !dir_req && !eng_req) |=> owner == 2'd0);
endmodule

bind wrr_bus_arbiter wrr_arb_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .dir_req   (dir_req),
   .eng_req   (eng_req),
   .xfer_done (xfer_done),
   .mode_wrr  (mode_wrr),
   .dir_gnt   (dir_gnt),
   .eng_gnt   (eng_gnt),
   .owner     (owner)
);

// File: tb/tb_wrr_bus_arbiter.sv
`timescale 1ns/1ps
module tb_wrr_bus_arbiter;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       dir_req = 1'b0, eng_req = 1'b0;
   logic       mode_wrr = 1'b0;
   logic [3:0] weight = 4'd0;
   logic       dir_gnt, eng_gnt;
   logic [1:0] owner;
   logic       done_auto = 1'b0, done_man = 1'b0, auto_on = 1'b1;
   logic       xfer_done;

   int n_chk = 0, n_fail = 0, gcount = 0;
   byte exp_q[$];

   always #2.5 clk = ~clk;
   assign xfer_done = done_auto | done_man;

   wrr_bus_arbiter dut (
      .clk(clk), .rst_n(rst_n), .dir_req(dir_req), .eng_req(eng_req),
      .xfer_done(xfer_done), .mode_wrr(mode_wrr), .weight(weight),
      .dir_gnt(dir_gnt), .eng_gnt(eng_gnt), .owner(owner)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // memory side: done one cycle after each grant
   always @(negedge clk)
      done_auto <= auto_on && (dir_gnt || eng_gnt);

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && (dir_gnt || eng_gnt)) begin
         byte got, want;
         got = dir_gnt ? "D" : "E";
         gcount++;
         check(!(dir_gnt && eng_gnt), "R2 exclusive grants", 1, 0);
         if (exp_q.size() == 0) begin
            check(1'b0, "R2 unexpected grant", int'(got), 0);
         end else begin
            want = exp_q.pop_front();
            check(got == want, "grant order R4/R5/R6/R7/R8/R9", int'(got), int'(want));
         end
         check(owner == (dir_gnt ? 2'd1 : 2'd2), "R3 owner on grant",
               owner, dir_gnt ? 1 : 2);
      end
   end

   task automatic expect_seq(input string s);
      for (int i = 0; i < s.len(); i++) exp_q.push_back(s[i]);
   endtask

   task automatic wait_grants(input int k);
      int target;
      target = gcount + k;
      while (gcount < target) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic settle(input string req);
      dir_req = 1'b0;
      eng_req = 1'b0;
      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, req, exp_q.size(), 0);
   endtask

   initial begin
      #1000000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(dir_gnt == 0 && eng_gnt == 0, "R1 grants in reset", dir_gnt + eng_gnt, 0);
      check(owner == 0, "R1 owner in reset", owner, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(owner == 0 && !dir_gnt && !eng_gnt, "R1 idle after reset", owner, 0);

      // R5 fixed priority, both requesting
      mode_wrr = 1'b0; weight = 4'd2;
      expect_seq("DDD");
      dir_req = 1; eng_req = 1;
      wait_grants(3); settle("R5 sequence complete");

      // R4 single requesters
      expect_seq("EE"); eng_req = 1;
      wait_grants(2); settle("R4 engine alone");
      mode_wrr = 1'b1;
      expect_seq("DD"); dir_req = 1;
      wait_grants(2); settle("R4 direct alone");

      // R6 weighted rounds, weight 2 then 0
      weight = 4'd2;
      expect_seq("DEEEDEEE"); dir_req = 1; eng_req = 1;
      wait_grants(8); settle("R6 weight 2 rounds");
      weight = 4'd0;
      expect_seq("DEDE"); dir_req = 1; eng_req = 1;
      wait_grants(4); settle("R6 weight 0 rounds");

      // R7 direct arrives during engine-only traffic
      weight = 4'd1;
      expect_seq("EEDEE"); eng_req = 1;
      wait_grants(2); dir_req = 1;
      wait_grants(3); settle("R7 direct wins next slot");

      // R8 round cleared when direct drops
      weight = 4'd3;
      expect_seq("DEED"); dir_req = 1; eng_req = 1;
      wait_grants(2); dir_req = 0;
      wait_grants(1); dir_req = 1;
      wait_grants(1); settle("R8 round reset");

      // R9 weight change mid-run
      weight = 4'd1;
      expect_seq("DEEDEEEE"); dir_req = 1; eng_req = 1;
      wait_grants(2); weight = 4'd3;
      wait_grants(6); settle("R9 weight captured at run start");

      // R10 stray done while idle
      auto_on = 1'b0;
      done_man = 1'b1; @(negedge clk); done_man = 1'b0;
      repeat (2) @(negedge clk);
      check(owner == 0 && !dir_gnt && !eng_gnt, "R10 stray done ignored", owner, 0);

      // R3 owner held until done
      expect_seq("D"); dir_req = 1;
      wait_grants(1); dir_req = 0; eng_req = 1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check(owner == 1, "R3 owner held while busy", owner, 1);
      end
      expect_seq("E");
      done_man = 1'b1; @(negedge clk); done_man = 1'b0;
      check(owner == 0, "R3 owner idle after done", owner, 0);
      wait_grants(1); eng_req = 0;
      done_man = 1'b1; @(negedge clk); done_man = 1'b0;
      auto_on = 1'b1;
      settle("R3 sequence complete");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule